// File: doc/BRIEF.md
# Banked Byte Register File with Pointer Indirection

This block is the data register file of a small 8-bit controller core. The core gives it a 7-bit file offset, read and write strobes and a write byte. A bank bit held inside the file's own status register decides which of two banks a direct offset selects. A handful of control registers answer at the same offset in both banks. A few other offsets hold a separate register per bank. General-purpose RAM is shared by both banks.

Offset zero is not storage. Any access there is redirected to the location named by the pointer register. The pointer's top bit picks the bank and its low seven bits pick the offset. A redirected access that points back at offset zero reads zero and does not store anything.

The execution unit updates the arithmetic flags through dedicated per-flag inputs, without a file write. The block drives the current bank bit and the three flags out as ports.

Top module: `bank_regfile`

## Requirements
- R1: After reset the status register reads 8'h18. This means the bank bit (status bit 5) is 0 and the flags (bits 2..0) are 0. Every other register reads zero.
- R2: Offsets 0x01, 0x05, 0x06, 0x08 and 0x09 each hold an independent byte per bank. Direct access picks the bank from status bit 5.
- R3: The program-counter low byte (0x02), status (0x03), pointer (0x04), PC-high buffer (0x0A) and interrupt control (0x0B) are single registers. They are reached identically from either bank.
- R4: A read or write at offset 0x00 acts on the location whose bank is pointer bit 7 and whose offset is pointer bits 6..0.
- R5: A redirected access whose target offset is 0x00 reads 8'h00, and a write there changes no state.
- R6: Offset 0x07 and offsets 0x50..0x7F read 8'h00 in both banks, and writes to them have no effect.
- R7: RAM at offsets 0x0C..0x4F is one store shared by both banks.
- R8: Output rp0 follows status bit 5. A file write to status stores bits 7..5 and 2..0, while bits 4 (time-out) and 3 (power-down) ignore file writes.
- R9: flagWe[i] loads flagVal[i] into status bit i, with bit 0 = carry, bit 1 = digit carry and bit 2 = zero. A flag update takes priority over a same-cycle file write to that bit. statusFlags outputs status bits 2..0.
- R10: The PC-high buffer stores only bits 4..0, and bits 7..5 always read 0.
- R11: rdData is 8'h00 whenever rdEn is low.
- R12: Reads are combinational in the cycle of the request. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Direct file offset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| flagWe | input | 3 | Per-flag update enables {zero, digit carry, carry} |
| flagVal | input | 3 | Per-flag update values |
| rdData | output | 8 | Read data |
| rp0 | output | 1 | Current bank-select bit |
| statusFlags | output | 3 | Current {zero, digit carry, carry} |

## Verification
The assertions check the following on every cycle:
- rdData is zero when there is no read.
- The unimplemented slot and the PC-high upper bits read zero.
- The bank bit follows a direct status write and holds when there is no write.
- Each flag follows its update input and holds when idle.

The bench scenarios, checked against a bench-side model, are needed to show the rest:
- A banked offset really keeps two bytes.
- The mirrored registers are shared between banks.
- Pointer redirection reaches the correct bank.
- The self-pointing case is inert.
- A flag update wins over a same-cycle status write.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 7;
  localparam int NUM_BANKS = 2;
  localparam int NUM_BANKED = 5;
  localparam int FLAG_CNT  = 3;

  localparam logic [ADDR_W-1:0] OFS_INDIRECT = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_PCL      = 7'h02;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 7'h03;
  localparam logic [ADDR_W-1:0] OFS_PTR      = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_PCHBUF   = 7'h0A;
  localparam logic [ADDR_W-1:0] OFS_INTCTL   = 7'h0B;

  localparam int ST_RP0 = 5;
  localparam int ST_TO  = 4;
  localparam int ST_PD  = 3;

  localparam logic [DATA_W-1:0] STATUS_RST = 8'h18;

  typedef enum logic [2:0] {
    SK_NONE   = 3'd0,
    SK_PCL    = 3'd1,
    SK_STATUS = 3'd2,
    SK_PTR    = 3'd3,
    SK_PCHBUF = 3'd4,
    SK_INTCTL = 3'd5,
    SK_BANKED = 3'd6,
    SK_GPR    = 3'd7
  } slotKind_e;

  typedef struct packed {
    logic              rdStrobe;
    logic              wrStrobe;
    slotKind_e         kind;
    logic              bank;
    logic [2:0]        bankIdx;
    logic [ADDR_W-1:0] gprIdx;
  } ctrlStrobes_t;

  // Maps a per-bank offset to its slot index; bit 3 flags a hit.
  function automatic logic [3:0] bankedSlot(input logic [ADDR_W-1:0] ofs);
    case (ofs)
      7'h01:   bankedSlot = 4'b1_000;
      7'h05:   bankedSlot = 4'b1_001;
      7'h06:   bankedSlot = 4'b1_010;
      7'h08:   bankedSlot = 4'b1_011;
      7'h09:   bankedSlot = 4'b1_100;
      default: bankedSlot = 4'b0_000;
    endcase
  endfunction

endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
#(
  parameter int GPR_FIRST = 12,
  parameter int GPR_LAST  = 79
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              rp0,
  input  logic [DATA_W-1:0] ptr,
  output ctrlStrobes_t      strobes
);

  localparam logic [ADDR_W-1:0] GPR_LO = ADDR_W'(GPR_FIRST);
  localparam logic [ADDR_W-1:0] GPR_HI = ADDR_W'(GPR_LAST);

  logic              isIndirect;
  logic              effBank;
  logic [ADDR_W-1:0] effOfs;
  logic [3:0]        bankHit;

  always_comb begin
    isIndirect = (addr == OFS_INDIRECT);
    effBank    = isIndirect ? ptr[DATA_W-1] : rp0;
    effOfs     = isIndirect ? ptr[ADDR_W-1:0] : addr;
    bankHit    = bankedSlot(effOfs);

    strobes          = '0;
    strobes.rdStrobe = rdEn;
    strobes.wrStrobe = wrEn;
    strobes.bank     = effBank;
    strobes.kind     = SK_NONE;

    if (effOfs == OFS_PCL) begin
      strobes.kind = SK_PCL;
    end else if (effOfs == OFS_STATUS) begin
      strobes.kind = SK_STATUS;
    end else if (effOfs == OFS_PTR) begin
      strobes.kind = SK_PTR;
    end else if (effOfs == OFS_PCHBUF) begin
      strobes.kind = SK_PCHBUF;
    end else if (effOfs == OFS_INTCTL) begin
      strobes.kind = SK_INTCTL;
    end else if (bankHit[3]) begin
      strobes.kind    = SK_BANKED;
      strobes.bankIdx = bankHit[2:0];
    end else if (effOfs >= GPR_LO && effOfs <= GPR_HI) begin
      strobes.kind   = SK_GPR;
      strobes.gprIdx = effOfs - GPR_LO;
    end
  end

endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
#(
  parameter int GPR_FIRST = 12,
  parameter int GPR_LAST  = 79,
  parameter int PCH_W     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [FLAG_CNT-1:0] flagWe,
  input  logic [FLAG_CNT-1:0] flagVal,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   statusQ,
  output logic [DATA_W-1:0]   ptrQ
);

  localparam int GPR_DEPTH = GPR_LAST - GPR_FIRST + 1;
  localparam int GPR_AW    = $clog2(GPR_DEPTH);

  logic [DATA_W-1:0] pclQ;
  logic [PCH_W-1:0]  pchQ;
  logic [DATA_W-1:0] intQ;
  logic [DATA_W-1:0] bankedQ [NUM_BANKS][NUM_BANKED];
  logic [DATA_W-1:0] gprQ    [GPR_DEPTH];
  logic [DATA_W-1:0] statusNext;
  logic              doWrite;
  logic [GPR_AW-1:0] gprSel;

  assign doWrite = strobes.wrStrobe;
  assign gprSel  = strobes.gprIdx[GPR_AW-1:0];

  // Status: file write keeps TO/PD, then flag inputs override their bits.
  always_comb begin
    statusNext = statusQ;
    if (doWrite && strobes.kind == SK_STATUS) begin
      statusNext        = wrData;
      statusNext[ST_TO] = statusQ[ST_TO];
      statusNext[ST_PD] = statusQ[ST_PD];
    end
    for (int i = 0; i < FLAG_CNT; i++) begin
      if (flagWe[i]) statusNext[i] = flagVal[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= STATUS_RST;
      ptrQ    <= '0;
      pclQ    <= '0;
      pchQ    <= '0;
      intQ    <= '0;
    end else begin
      statusQ <= statusNext;
      if (doWrite && strobes.kind == SK_PTR)    ptrQ <= wrData;
      if (doWrite && strobes.kind == SK_PCL)    pclQ <= wrData;
      if (doWrite && strobes.kind == SK_PCHBUF) pchQ <= wrData[PCH_W-1:0];
      if (doWrite && strobes.kind == SK_INTCTL) intQ <= wrData;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar s = 0; s < NUM_BANKED; s++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bankedQ[b][s] <= '0;
        end else if (doWrite && strobes.kind == SK_BANKED &&
                     strobes.bank == 1'(b) && strobes.bankIdx == 3'(s)) begin
          bankedQ[b][s] <= wrData;
        end
      end
    end
  end

  for (genvar g = 0; g < GPR_DEPTH; g++) begin : g_gpr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gprQ[g] <= '0;
      end else if (doWrite && strobes.kind == SK_GPR && gprSel == GPR_AW'(g)) begin
        gprQ[g] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdStrobe) begin
      case (strobes.kind)
        SK_PCL:    rdData = pclQ;
        SK_STATUS: rdData = statusQ;
        SK_PTR:    rdData = ptrQ;
        SK_PCHBUF: rdData = {{(DATA_W-PCH_W){1'b0}}, pchQ};
        SK_INTCTL: rdData = intQ;
        SK_BANKED: rdData = bankedQ[strobes.bank][strobes.bankIdx];
        SK_GPR:    rdData = gprQ[gprSel];
        default:   rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import regfile_pkg::*;
#(
  parameter int GPR_FIRST = 12,
  parameter int GPR_LAST  = 79,
  parameter int PCH_W     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [FLAG_CNT-1:0] flagWe,
  input  logic [FLAG_CNT-1:0] flagVal,
  output logic [DATA_W-1:0]   rdData,
  output logic                rp0,
  output logic [FLAG_CNT-1:0] statusFlags
);

  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] ptrQ;

  assign rp0         = statusQ[ST_RP0];
  assign statusFlags = statusQ[FLAG_CNT-1:0];

  regfile_ctrl #(
    .GPR_FIRST (GPR_FIRST),
    .GPR_LAST  (GPR_LAST)
  ) i_ctrl (
    .addr    (addr),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .rp0     (rp0),
    .ptr     (ptrQ),
    .strobes (strobes)
  );

  regfile_dp #(
    .GPR_FIRST (GPR_FIRST),
    .GPR_LAST  (GPR_LAST),
    .PCH_W     (PCH_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .flagWe  (flagWe),
    .flagVal (flagVal),
    .rdData  (rdData),
    .statusQ (statusQ),
    .ptrQ    (ptrQ)
  );

endmodule

// File: rtl/regfile_chk.sv
module regfile_chk (
  input logic       clk,
  input logic       rstN,
  input logic [6:0] addr,
  input logic       rdEn,
  input logic       wrEn,
  input logic       wrBank,
  input logic [2:0] flagWe,
  input logic [2:0] flagVal,
  input logic [7:0] rdData,
  input logic       rp0,
  input logic [2:0] statusFlags
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!rp0 && statusFlags == 3'b000)); // R1

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == 8'h00); // R11

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 7'h07) |-> rdData == 8'h00); // R6

  AST_PCHBUF_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 7'h0A) |-> rdData[7:5] == 3'b000); // R10

  AST_BANK_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 7'h03) |=> rp0 == $past(wrBank)); // R8

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rp0)); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && flagWe == 3'b000) |=> $stable(statusFlags)); // R9

  for (genvar i = 0; i < 3; i++) begin : g_flag
    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      flagWe[i] |=> statusFlags[i] == $past(flagVal[i])); // R9
  end

endmodule

bind bank_regfile regfile_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .addr        (addr),
  .rdEn        (rdEn),
  .wrEn        (wrEn),
  .wrBank      (wrData[5]),
  .flagWe      (flagWe),
  .flagVal     (flagVal),
  .rdData      (rdData),
  .rp0         (rp0),
  .statusFlags (statusFlags)
);

// File: tb/test_bank_regfile.sv
`timescale 1ns/1ps
module test_bank_regfile;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] addr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] flagWe = '0;
  logic [2:0] flagVal = '0;
  logic [7:0] rdData;
  logic       rp0;
  logic [2:0] statusFlags;

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  // Bench model of the file
  logic [7:0] mStatus, mPtr, mPcl, mPch, mInt;
  logic [7:0] mBanked [2][5];
  logic [7:0] mGpr [68];

  always #2 clk = ~clk;

  bank_regfile i_bank_regfile (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .flagWe(flagWe), .flagVal(flagVal),
    .rdData(rdData), .rp0(rp0), .statusFlags(statusFlags)
  );

  function automatic int slotOf(input logic [6:0] ofs);
    case (ofs)
      7'h01: return 0;
      7'h05: return 1;
      7'h06: return 2;
      7'h08: return 3;
      7'h09: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] peek(input logic bank, input logic [6:0] ofs);
    if (ofs == 7'h02) return mPcl;
    if (ofs == 7'h03) return mStatus;
    if (ofs == 7'h04) return mPtr;
    if (ofs == 7'h0A) return mPch & 8'h1F;
    if (ofs == 7'h0B) return mInt;
    if (slotOf(ofs) >= 0) return mBanked[bank][slotOf(ofs)];
    if (ofs >= 7'h0C && ofs <= 7'h4F) return mGpr[ofs - 7'h0C];
    return 8'h00;
  endfunction

  function automatic logic [7:0] expRead(input logic [6:0] a);
    if (a == 7'h00) return peek(mPtr[7], mPtr[6:0]);
    return peek(mStatus[5], a);
  endfunction

  function automatic string tagOf(input logic [6:0] a);
    if (a == 7'h00) return (mPtr[6:0] == 7'h00) ? "R5 self-pointer" : "R4 indirect";
    if (slotOf(a) >= 0) return "R2 banked";
    if (a == 7'h0A) return "R10 pc-high buffer";
    if (a == 7'h03) return "R8 status";
    if (a == 7'h02 || a == 7'h04 || a == 7'h0B) return "R3 mirrored";
    if (a >= 7'h0C && a <= 7'h4F) return "R7 shared RAM";
    return "R6 unimplemented";
  endfunction

  task automatic modelWrite(input logic [6:0] a, input logic wr, input logic [7:0] d,
                            input logic [2:0] fwe, input logic [2:0] fv);
    logic       bank;
    logic [6:0] ofs;
    logic [7:0] nextStatus;
    bank = (a == 7'h00) ? mPtr[7] : mStatus[5];
    ofs  = (a == 7'h00) ? mPtr[6:0] : a;
    nextStatus = mStatus;
    if (wr) begin
      if (ofs == 7'h02) mPcl = d;
      else if (ofs == 7'h03) nextStatus = {d[7:5], mStatus[4:3], d[2:0]};
      else if (ofs == 7'h04) mPtr = d;
      else if (ofs == 7'h0A) mPch = d & 8'h1F;
      else if (ofs == 7'h0B) mInt = d;
      else if (slotOf(ofs) >= 0) mBanked[bank][slotOf(ofs)] = d;
      else if (ofs >= 7'h0C && ofs <= 7'h4F) mGpr[ofs - 7'h0C] = d;
    end
    for (int i = 0; i < 3; i++) if (fwe[i]) nextStatus[i] = fv[i];
    mStatus = nextStatus;
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [6:0] a, input logic rd, input logic wr, input logic [7:0] d,
                      input logic [2:0] fwe, input logic [2:0] fv, input string tag);
    @(negedge clk);
    addr = a; rdEn = rd; wrEn = wr; wrData = d; flagWe = fwe; flagVal = fv;
    #1;
    if (rd) check(rdData, expRead(a), tag);
    else    check(rdData, 8'h00, "R11 idle read");
    check({7'b0, rp0}, {7'b0, mStatus[5]}, "R8 bank output");
    check({5'b0, statusFlags}, {5'b0, mStatus[2:0]}, "R9 flag output");
    modelWrite(a, wr, d, fwe, fv);
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    doOp(a, 1'b1, 1'b0, 8'h00, 3'b000, 3'b000, tag);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    doOp(a, 1'b0, 1'b1, d, 3'b000, 3'b000, "R12 write");
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFail++;
      $display("FAIL R12 watchdog: actual hang expected completion");
      finishRun();
    end
  end

  initial begin
    mStatus = 8'h18; mPtr = 0; mPcl = 0; mPch = 0; mInt = 0;
    for (int b = 0; b < 2; b++) for (int s = 0; s < 5; s++) mBanked[b][s] = 0;
    for (int g = 0; g < 68; g++) mGpr[g] = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk); addr = 7'h03; rdEn = 1'b1; #1;
    check(rdData, 8'h18, "R1 status reset");
    check({7'b0, rp0}, 8'h00, "R1 bank bit reset");
    rdEn = 1'b0;
    rd(7'h04, "R1 pointer reset");
    rd(7'h05, "R1 banked reset");

    // R2 banked storage
    wr(7'h05, 8'hA5);
    wr(7'h03, 8'h20);
    rd(7'h03, "R8 status TO/PD kept");
    wr(7'h05, 8'h5A);
    rd(7'h05, "R2 bank1 slot");
    wr(7'h0B, 8'h3C);
    wr(7'h02, 8'h11);
    wr(7'h03, 8'h00);
    rd(7'h05, "R2 bank0 slot");
    rd(7'h0B, "R3 mirrored intctl");
    rd(7'h02, "R3 mirrored pcl");

    // R4 indirect into bank1 banked slot, R7 shared RAM
    wr(7'h04, 8'h85);
    wr(7'h00, 8'h77);
    rd(7'h00, "R4 indirect read");
    wr(7'h03, 8'h20);
    rd(7'h05, "R4 indirect landed bank1");
    wr(7'h20, 8'hC3);
    wr(7'h03, 8'h00);
    rd(7'h20, "R7 shared RAM bank0 view");
    rd(7'h20, "R12 read after write");

    // R5 self-pointing indirect
    wr(7'h04, 8'h00);
    wr(7'h00, 8'hFF);
    rd(7'h00, "R5 self-pointer read");
    wr(7'h04, 8'h80);
    wr(7'h00, 8'hEE);
    rd(7'h00, "R5 self-pointer bank1");
    rd(7'h05, "R5 no side effect");

    // R6 unimplemented
    wr(7'h07, 8'hFF);
    rd(7'h07, "R6 offset 7");
    wr(7'h60, 8'h99);
    rd(7'h60, "R6 upper range");

    // R10 pc-high buffer
    wr(7'h0A, 8'hFF);
    rd(7'h0A, "R10 pc-high buffer");

    // R9 flag priority over file write to status
    doOp(7'h03, 1'b0, 1'b1, 8'h07, 3'b101, 3'b000, "R9 flag vs write");
    rd(7'h03, "R9 flag priority");
    doOp(7'h10, 1'b0, 1'b0, 8'h00, 3'b111, 3'b101, "R9 flag only");
    rd(7'h03, "R9 flag load");

    // Randomized traffic with a fixed seed
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] a;
      logic [7:0] d;
      logic [2:0] fwe, fv;
      logic       r, w;
      int         pick;
      pick = $urandom % 4;
      case (pick)
        0: a = 7'($urandom % 16);
        1: a = 7'h00;
        default: a = 7'($urandom % 128);
      endcase
      d   = 8'($urandom);
      r   = 1'($urandom % 4 != 0);
      w   = 1'($urandom % 2);
      fwe = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
      fv  = 3'($urandom);
      doOp(a, r, w, d, fwe, fv, tagOf(a));
    end

    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; flagWe = 3'b000;
    done = 1'b1;
    finishRun();
  end

endmodule